// File: doc/BRIEF.md
# Single-Flag Compare and Branch Unit

This block produces the one condition bit of a processor that keeps no multi-bit condition code. A compare instruction hands the block two operands and a four-bit condition selector. The block forms the two's-complement difference of the operands and derives zero, sign, borrow and signed-overflow terms from it. These terms exist only for that one compare. The selected condition is reduced to a single bit, which is written into the architectural flag register on the next clock edge.

Branches consult only that stored bit. The fetch stage states whether the branch fires on a set flag or on a clear flag, and it receives a taken indication. A flag readout path returns the stored bit as a zero-extended word, so the bit can be copied into a general-purpose register.

Top module: `cmpflag_unit`

## Requirements
- R1: A synchronous active-high reset clears the flag, so the readout word is 0 in the cycle after reset.
- R2: Selector 0 (equal) sets the flag when the operands are identical. Selector 1 (not equal) sets the flag when they differ.
- R3: Selectors 2, 3, 4 and 5 give signed greater-than, greater-or-equal, less-than and less-or-equal on two's-complement operands. Signed less-than is taken from the sign of the difference XOR the overflow term, so the result stays correct when the subtraction overflows.
- R4: Selectors 6, 7, 8 and 9 give unsigned greater-than, greater-or-equal, less-than and less-or-equal. Unsigned less-than is the borrow out of the subtraction.
- R5: A compare with selector 10 through 15 writes 0 into the flag.
- R6: The flag takes the compare result at the clock edge that samples `cmp_valid` high. The branch decision and the readout show the new value in the next cycle.
- R7: While `cmp_valid` is low, operand and selector changes leave the flag unchanged.
- R8: `br_taken` is high only while `br_valid` is high. With `br_on_set`=1 it follows the flag. With `br_on_set`=0 it follows the inverted flag.
- R9: `flag_word` carries the flag in bit 0, and all of its upper bits are 0.
- R10: A branch presented in the same cycle as a compare is decided on the flag value held before that compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | A compare instruction is present this cycle |
| cmp_a | input | WIDTH | First operand (minuend) |
| cmp_b | input | WIDTH | Second operand (subtrahend) |
| cmp_cond | input | 4 | Condition selector |
| br_valid | input | 1 | A conditional branch is present this cycle |
| br_on_set | input | 1 | 1: branch fires on a set flag, 0: branch fires on a clear flag |
| br_taken | output | 1 | Branch decision sent to fetch |
| flag_word | output | WIDTH | Flag zero-extended to a register word |

## Verification
The hardest cases to reach are the signed compares whose subtraction overflows, where the sign of the difference alone gives the wrong answer. Examples are a most-negative operand compared against a positive one, and a positive operand compared against a negative one across the wrap boundary. The bench reaches every such pair by sweeping all operand pairs under every selector on a four-bit instance. A second situation is a branch issued in the same cycle as a compare that changes the flag. The bench forces it by first setting the flag and then issuing a clearing compare together with a branch.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_EQ  = 4'd0,
        SEL_NE  = 4'd1,
        SEL_GTS = 4'd2,
        SEL_GES = 4'd3,
        SEL_LTS = 4'd4,
        SEL_LES = 4'd5,
        SEL_GTU = 4'd6,
        SEL_GEU = 4'd7,
        SEL_LTU = 4'd8,
        SEL_LEU = 4'd9
    } cmp_sel_e;

    // Terms derived from one subtraction; never stored architecturally.
    typedef struct packed {
        logic zero;
        logic neg;
        logic borrow;
        logic ovf;
    } diff_terms_t;

    function automatic logic signed_less(diff_terms_t t);
        return t.neg ^ t.ovf;
    endfunction

    function automatic logic reduce_cond(diff_terms_t t, logic [SEL_W-1:0] sel);
        logic lt_s;
        logic lt_u;
        logic res;
        lt_s = signed_less(t);
        lt_u = t.borrow;
        case (sel)
            SEL_EQ:  res = t.zero;
            SEL_NE:  res = ~t.zero;
            SEL_GTS: res = ~(lt_s | t.zero);
            SEL_GES: res = ~lt_s;
            SEL_LTS: res = lt_s;
            SEL_LES: res = lt_s | t.zero;
            SEL_GTU: res = ~(lt_u | t.zero);
            SEL_GEU: res = ~lt_u;
            SEL_LTU: res = lt_u;
            SEL_LEU: res = lt_u | t.zero;
            default: res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/cmpflag_sub.sv
module cmpflag_sub
    import cmpflag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output diff_terms_t      terms
);
    localparam int EXT_W = WIDTH + 1;
    localparam int MSB   = WIDTH - 1;

    logic [EXT_W-1:0] diff_ext;
    logic [WIDTH-1:0] diff;

    always_comb begin
        diff_ext = {1'b0, op_a} - {1'b0, op_b};
        diff     = diff_ext[WIDTH-1:0];
        terms.zero   = (diff == '0);
        terms.neg    = diff[MSB];
        terms.borrow = diff_ext[WIDTH];
        terms.ovf    = (op_a[MSB] ^ op_b[MSB]) & (op_a[MSB] ^ diff[MSB]);
    end
endmodule

// File: rtl/cmpflag_cond.sv
module cmpflag_cond
    import cmpflag_pkg::*;
(
    input  diff_terms_t      terms,
    input  logic [SEL_W-1:0] sel,
    output logic             result
);
    always_comb begin
        result = reduce_cond(terms, sel);
    end
endmodule

// File: rtl/cmpflag_reg.sv
module cmpflag_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (wr_en)
            flag_q <= wr_val;
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !flag_q);
    a_r6_write_next: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flag_q == $past(wr_val)));
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flag_q));
endmodule

// File: rtl/cmpflag_branch.sv
module cmpflag_branch (
    input  logic flag,
    input  logic br_valid,
    input  logic br_on_set,
    output logic taken
);
    always_comb begin
        taken = br_valid & ~(flag ^ br_on_set);
    end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_valid,
    input  logic [WIDTH-1:0] cmp_a,
    input  logic [WIDTH-1:0] cmp_b,
    input  logic [3:0]       cmp_cond,
    input  logic             br_valid,
    input  logic             br_on_set,
    output logic             br_taken,
    output logic [WIDTH-1:0] flag_word
);
    localparam int PAD_W = WIDTH - 1;

    diff_terms_t terms;
    logic        cond_res;
    logic        flag_q;

    cmpflag_sub #(.WIDTH(WIDTH)) u_sub (
        .op_a  (cmp_a),
        .op_b  (cmp_b),
        .terms (terms)
    );

    cmpflag_cond u_cond (
        .terms  (terms),
        .sel    (cmp_cond),
        .result (cond_res)
    );

    cmpflag_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cmp_valid),
        .wr_val (cond_res),
        .flag_q (flag_q)
    );

    cmpflag_branch u_branch (
        .flag      (flag_q),
        .br_valid  (br_valid),
        .br_on_set (br_on_set),
        .taken     (br_taken)
    );

    assign flag_word = {{PAD_W{1'b0}}, flag_q};

    a_r2_zero_term: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> (terms.zero == (cmp_a == cmp_b)));
    a_r4_borrow_term: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> (terms.borrow == (cmp_a < cmp_b)));
    a_r3_signed_lt: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_cond == SEL_LTS) |=> (flag_q == $past($signed(cmp_a) < $signed(cmp_b))));
    a_r5_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_cond > SEL_LEU) |=> !flag_q);
    a_r8_needs_valid: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> br_valid);
endmodule

// File: tb/cmpflag_unit_bench.sv
module cmpflag_unit_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmp_valid;
    logic [W-1:0] cmp_a;
    logic [W-1:0] cmp_b;
    logic [3:0]   cmp_cond;
    logic         br_valid;
    logic         br_on_set;
    logic         br_taken;
    logic [W-1:0] flag_word;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    cmpflag_unit #(.WIDTH(W)) u_cmpflag_unit (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .cmp_cond  (cmp_cond),
        .br_valid  (br_valid),
        .br_on_set (br_on_set),
        .br_taken  (br_taken),
        .flag_word (flag_word)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model(int a, int b, int c);
        int sa = (a >= 8) ? a - 16 : a;
        int sb = (b >= 8) ? b - 16 : b;
        case (c)
            0: return a == b;
            1: return a != b;
            2: return sa > sb;
            3: return sa >= sb;
            4: return sa < sb;
            5: return sa <= sb;
            6: return a > b;
            7: return a >= b;
            8: return a < b;
            9: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int c);
        if (c < 2) return "R2";
        if (c < 6) return "R3";
        if (c < 10) return "R4";
        return "R5";
    endfunction

    initial begin
        rst = 1'b1; cmp_valid = 1'b0; cmp_a = '0; cmp_b = '0; cmp_cond = '0;
        br_valid = 1'b0; br_on_set = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk(flag_word == 0, "R1 word", flag_word, 0);
        br_valid = 1'b1; br_on_set = 1'b0; #1;
        chk(br_taken == 1'b1, "R1 clear-branch", br_taken, 1);
        br_valid = 1'b0;

        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    bit exp;
                    exp = model(a, b, c);
                    cmp_valid = 1'b1; cmp_a = W'(a); cmp_b = W'(b); cmp_cond = 4'(c);
                    @(negedge clk);
                    // R6 / R9: new flag visible one cycle later, zero-extended
                    chk(flag_word == {3'b000, exp}, tag_of(c), flag_word, exp);
                    br_valid = 1'b1; br_on_set = 1'b1; #1;
                    chk(br_taken == exp, "R8 on-set", br_taken, exp);
                    br_on_set = 1'b0; #1;
                    chk(br_taken == !exp, "R8 on-clear", br_taken, !exp);
                    br_valid = 1'b0; #1;
                    chk(br_taken == 1'b0, "R8 no-valid", br_taken, 0);
                    // R7: idle cycle with disturbed inputs
                    cmp_valid = 1'b0; cmp_a = ~W'(a); cmp_b = W'(b + 5); cmp_cond = 4'(c ^ 1);
                    @(negedge clk);
                    chk(flag_word == {3'b000, exp}, "R7 hold", flag_word, exp);
                end
            end
        end

        // R10: same-cycle compare and branch sees old flag
        cmp_valid = 1'b1; cmp_a = 4'd3; cmp_b = 4'd3; cmp_cond = 4'd0;
        @(negedge clk);
        cmp_cond = 4'd1; br_valid = 1'b1; br_on_set = 1'b1; #1;
        chk(br_taken == 1'b1, "R10 old flag", br_taken, 1);
        @(negedge clk);
        cmp_valid = 1'b0; #1;
        chk(br_taken == 1'b0, "R10 new flag", br_taken, 0);
        br_valid = 1'b0;

        // R1: reset mid-run clears a set flag
        cmp_valid = 1'b1; cmp_cond = 4'd0;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(flag_word == 1, "R1 preset", flag_word, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(flag_word == 0, "R1 mid-run", flag_word, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule